// File: doc/BRIEF.md
# E3 Transmit Payload Input Aligner

This block takes transmit payload for a clear-channel E3 framer and turns it into a bit stream that is aligned to frame boundaries. Each bit leaves with its position inside the frame, and a strobe marks the first bit of every frame. A downstream frame generator uses these outputs to build the frame. Payload enters either one bit at a time or as 4-bit nibbles. Each nibble covers four bit periods and is sent most significant bit first.

The whole block runs on one clock. Two enable inputs mark the cycles in which a payload bit period happens. One enable belongs to the local transmit input clock and the other to the recovered line clock. Loop timing selects the recovered enable and local timing selects the local enable. Under local timing the frame is either self-timed (master) or aligned to rising edges of a frame-reference input (slave). This gives six operating modes from three configuration inputs.

The configuration inputs are loaded into the active mode during reset. After reset they are loaded only at a frame boundary, so a frame is never cut by a mode change.

Top module: `e3_tx_payload_in`

## Requirements
- R1: When `cfg_loop`=1, `cfg_slave` has no effect: the frame free-runs and the first qualifying tick after reset gives `bit_pos`=0 with `frame_start`=1, whatever the level of `frame_ref`.
- R2: Under local timing, a tick is a clock cycle with `loc_en`=1 and `rec_en` is ignored. One clock after each tick, `bit_valid`=1 and `bit_out` carries the bit sampled at that tick. `bit_valid` is 0 one clock after every cycle that is not a tick.
- R3: Under loop timing, a tick is a clock cycle with `rec_en`=1 and `loc_en` is ignored. The output timing is the same as in R2.
- R4: `bit_pos` goes up by one on each emitted bit, from 0 to 1535, and then wraps to 0. It holds its value when no bit is emitted.
- R5: In master and loop modes, `frame_start` is 1 for exactly the one clock in which the bit at position 0 is presented with `bit_valid`=1.
- R6: In slave mode, before the first rising edge of `frame_ref` after reset, emitted bits carry `bit_pos`=0 and `frame_start` stays 0.
- R7: In slave mode, `frame_ref` is sampled only on ticks. A tick where it reads 1, after it read 0 on the previous tick, restarts the frame: that bit gets `bit_pos`=0 and `frame_start`=1. This also happens mid-frame, which truncates the running frame. A level that stays high does not restart the frame.
- R8: In nibble mode, `nib_take` is 1 combinationally in a tick whose bit position is a multiple of 4, and `nib_in` is captured in that tick. The four bits come out as `nib_in[3]`, `nib_in[2]`, `nib_in[1]`, `nib_in[0]`. In any other cycle `nib_take` is 0 and `nib_in` has no effect.
- R9: A change on the configuration inputs takes effect only after the tick that emits position 1535. Ticks before that still follow the old mode.
- R10: While `rst_n`=0 and on the first clock after it, `bit_valid`, `frame_start`, `bit_out` and `bit_pos` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nibble | input | 1 | 1 = nibble-parallel payload, 0 = serial |
| cfg_loop | input | 1 | 1 = loop timing (recovered enable), 0 = local timing |
| cfg_slave | input | 1 | 1 = align to frame reference (local timing only) |
| loc_en | input | 1 | Local transmit clock qualifier |
| rec_en | input | 1 | Recovered clock qualifier |
| ser_in | input | 1 | Serial payload bit |
| nib_in | input | 4 | Payload nibble, bit 3 sent first |
| frame_ref | input | 1 | Frame reference, synchronous to local ticks |
| nib_take | output | 1 | Nibble accepted this cycle |
| bit_out | output | 1 | Aligned payload bit |
| bit_valid | output | 1 | `bit_out` is a new bit this clock |
| bit_pos | output | 11 | Frame position of `bit_out` |
| frame_start | output | 1 | First bit of a frame |

## Verification
Serial payload is driven with `loc_en` and `rec_en` set on their own, together and not at all, so a tick on the wrong qualifier would show up as a wrong valid. Alternating and repeated nibble values show the bit order within a nibble, and a nibble offered between accepted ones shows whether it is ignored. For the frame reference, the bench tries a held high level, a rising edge before any frame is running and a rising edge in the middle of a frame, which separates edge detection from level detection. One frame runs in full while the configuration changes partway through, which checks both the wrap at position 1535 and the deferred mode load.

// File: rtl/e3_txp_pkg.sv
// Shared types for the E3 transmit payload aligner.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package e3_txp_pkg;

    // Operating mode selected by three configuration bits.
    typedef struct packed {
        logic nibble;   // 1 = 4-bit parallel payload
        logic loop;     // 1 = recovered clock qualifier
        logic slave;    // 1 = follow frame reference (local timing only)
    } txp_mode_t;

endpackage

// File: rtl/e3_txp_ref_edge.sv
// Frame-reference rising-edge detector.
// Samples the reference only on ticks; a rise is the current level 1 against
// a previously sampled 0. Assumes the reference is synchronous to the local
// tick qualifier, so no synchronizer stage is added.
module e3_txp_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ref_in,
    output logic rise
);
    logic ref_q;

    // Hold the level seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_q <= 1'b0;
        else if (tick) ref_q <= ref_in;
    end

    assign rise = tick & ref_in & ~ref_q;
endmodule

// File: rtl/e3_txp_frame_ctr.sv
// Frame position counter and active-mode register.
// Picks the tick qualifier for the active timing mode, keeps the frame
// position, handles slave restarts and loads new configuration only at frame
// boundaries (or while a slave frame has not yet started).
// Assumes FRAME_BITS >= 2.
module e3_txp_frame_ctr
    import e3_txp_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  txp_mode_t        cfg_mode,
    input  logic             loc_en,
    input  logic             rec_en,
    input  logic             rise,
    output logic             tick,
    output logic [POS_W-1:0] cur_pos,
    output logic             act_loop,
    output logic             act_nibble,
    output logic [POS_W-1:0] bit_pos,
    output logic             bit_valid,
    output logic             frame_start
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    txp_mode_t        act_q;
    logic [POS_W-1:0] cnt_q;
    logic             started_q;
    logic             slave_eff;
    logic             restart;
    logic             running;
    logic             at_last;
    logic             boundary;

    // Qualifier, restart and boundary decode for the current cycle.
    always_comb begin
        tick      = act_q.loop ? rec_en : loc_en;
        slave_eff = act_q.slave & ~act_q.loop;
        restart   = slave_eff & rise;
        running   = ~slave_eff | started_q | rise;
        cur_pos   = (restart | ~running) ? '0 : cnt_q;
        at_last   = (cur_pos == LAST);
        boundary  = tick & (at_last | ~running);
    end

    assign act_loop   = act_q.loop;
    assign act_nibble = act_q.nibble;

    // Advance position, register outputs and apply mode at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q       <= cfg_mode;
            cnt_q       <= '0;
            started_q   <= 1'b0;
            bit_pos     <= '0;
            bit_valid   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            bit_valid   <= tick;
            frame_start <= tick & running & (cur_pos == '0);
            if (tick) begin
                bit_pos <= cur_pos;
                cnt_q   <= (~running | at_last) ? '0 : cur_pos + POS_W'(1);
            end
            if (boundary) act_q <= cfg_mode;
            if (boundary && (!cfg_mode.slave || cfg_mode.loop))
                started_q <= 1'b0;
            else if (restart)
                started_q <= 1'b1;
        end
    end
endmodule

// File: rtl/e3_txp_serializer.sv
// Payload bit selector.
// Serial mode passes the input bit on each tick. Nibble mode captures a nibble
// at lane 0 of each group and shifts it out MSB first over the following ticks.
// Assumes NIB_W is a power of two and >= 2.
module e3_txp_serializer #(
    parameter int NIB_W  = 4,
    localparam int SEL_W = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             nibble_mode,
    input  logic [SEL_W-1:0] lane,
    input  logic             ser_in,
    input  logic [NIB_W-1:0] nib_in,
    output logic             nib_take,
    output logic             bit_out
);
    logic [NIB_W-2:0] sh_q;

    assign nib_take = tick & nibble_mode & (lane == '0);

    // Select the next payload bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            sh_q    <= '0;
        end else if (tick) begin
            if (!nibble_mode) begin
                bit_out <= ser_in;
            end else if (nib_take) begin
                bit_out <= nib_in[NIB_W-1];
                sh_q    <= nib_in[NIB_W-2:0];
            end else begin
                bit_out <= sh_q[NIB_W-2];
                sh_q    <= sh_q << 1;
            end
        end
    end
endmodule

// File: rtl/e3_tx_payload_in.sv
// E3 transmit payload input aligner (top).
// Combines the frame counter, reference edge detector and serializer into one
// single-clock block with six modes. Assumes both clock qualifiers are already
// in the clk domain and frame_ref is synchronous to the local qualifier.
module e3_tx_payload_in
    import e3_txp_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int NIB_W      = 4,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int SEL_W     = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nibble,
    input  logic             cfg_loop,
    input  logic             cfg_slave,
    input  logic             loc_en,
    input  logic             rec_en,
    input  logic             ser_in,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             frame_ref,
    output logic             nib_take,
    output logic             bit_out,
    output logic             bit_valid,
    output logic [POS_W-1:0] bit_pos,
    output logic             frame_start
);
    txp_mode_t        cfg_mode;
    logic             tick;
    logic             rise;
    logic [POS_W-1:0] cur_pos;
    logic             act_loop;
    logic             act_nibble;

    assign cfg_mode = '{nibble: cfg_nibble, loop: cfg_loop, slave: cfg_slave};

    e3_txp_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .loc_en      (loc_en),
        .rec_en      (rec_en),
        .rise        (rise),
        .tick        (tick),
        .cur_pos     (cur_pos),
        .act_loop    (act_loop),
        .act_nibble  (act_nibble),
        .bit_pos     (bit_pos),
        .bit_valid   (bit_valid),
        .frame_start (frame_start)
    );

    e3_txp_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ref_in (frame_ref),
        .rise   (rise)
    );

    e3_txp_serializer #(.NIB_W(NIB_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .nibble_mode (act_nibble),
        .lane        (cur_pos[SEL_W-1:0]),
        .ser_in      (ser_in),
        .nib_in      (nib_in),
        .nib_take    (nib_take),
        .bit_out     (bit_out)
    );
endmodule

// File: rtl/e3_txp_in_chk.sv
// Property checker for the E3 transmit payload aligner, bound to the top.
// Assumes the bound signals are the top's ports and its active-mode wires.
module e3_txp_in_chk #(
    parameter int FRAME_BITS = 1536,
    parameter int NIB_W      = 4,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loc_en,
    input logic             rec_en,
    input logic             act_loop,
    input logic             nib_take,
    input logic             bit_valid,
    input logic [POS_W-1:0] bit_pos,
    input logic             frame_start
);
    logic [POS_W-1:0] prev_pos;
    logic             seen;

    // Remember the position of the last emitted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pos <= '0;
            seen     <= 1'b0;
        end else if (bit_valid) begin
            prev_pos <= bit_pos;
            seen     <= 1'b1;
        end
    end

    // R5
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_valid && bit_pos == '0));

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= POS_W'(FRAME_BITS - 1));

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && seen && bit_pos != '0) |-> (bit_pos == POS_W'(prev_pos + 1'b1)));

    // R3
    loop_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_loop && !rec_en) |=> !bit_valid);

    // R2
    local_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_loop && !loc_en) |=> !bit_valid);

    // R8
    nib_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |=> (bit_valid && (int'(bit_pos) % NIB_W) == 0));
endmodule

bind e3_tx_payload_in e3_txp_in_chk #(.FRAME_BITS(FRAME_BITS), .NIB_W(NIB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_en      (loc_en),
    .rec_en      (rec_en),
    .act_loop    (act_loop),
    .nib_take    (nib_take),
    .bit_valid   (bit_valid),
    .bit_pos     (bit_pos),
    .frame_start (frame_start)
);

// File: tb/test_e3_tx_payload_in.sv
// Self-checking bench for the E3 transmit payload aligner.
module test_e3_tx_payload_in;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nibble = 1'b0, cfg_loop = 1'b0, cfg_slave = 1'b0;
    logic        loc_en = 1'b0, rec_en = 1'b0, ser_in = 1'b0, frame_ref = 1'b0;
    logic [3:0]  nib_in = 4'h0;
    logic        nib_take, bit_out, bit_valid, frame_start;
    logic [10:0] bit_pos;
    logic        take_s;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    e3_tx_payload_in i_e3_tx_payload_in (
        .clk(clk), .rst_n(rst_n), .cfg_nibble(cfg_nibble), .cfg_loop(cfg_loop),
        .cfg_slave(cfg_slave), .loc_en(loc_en), .rec_en(rec_en), .ser_in(ser_in),
        .nib_in(nib_in), .frame_ref(frame_ref), .nib_take(nib_take),
        .bit_out(bit_out), .bit_valid(bit_valid), .bit_pos(bit_pos),
        .frame_start(frame_start)
    );

    typedef struct packed {
        logic loc; logic rec; logic ser; logic val; logic dat;
    } vec_t;

    // Local master serial: {loc_en, rec_en, ser_in, expected valid, expected bit}
    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; observe after the rising edge.
    task automatic step(input logic l, input logic r, input logic s,
                        input logic [3:0] n, input logic f);
        @(negedge clk);
        loc_en = l; rec_en = r; ser_in = s; nib_in = n; frame_ref = f;
        #1 take_s = nib_take;
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset(input logic nb, input logic lp, input logic sl);
        @(negedge clk);
        rst_n = 1'b0; cfg_nibble = nb; cfg_loop = lp; cfg_slave = sl;
        loc_en = 1'b0; rec_en = 1'b0; frame_ref = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_pos;
        // R10 reset state
        do_reset(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 4'h0, 1'b0);
        chk("R10 valid", bit_valid, 0);
        chk("R10 frame_start", frame_start, 0);
        chk("R10 pos", bit_pos, 0);
        chk("R10 bit", bit_out, 0);

        // R2 R4 R5 vector walk, local master serial
        exp_pos = 0;
        foreach (VECS[i]) begin
            step(VECS[i].loc, VECS[i].rec, VECS[i].ser, 4'h0, 1'b0);
            chk("R2 valid", bit_valid, VECS[i].val);
            if (VECS[i].val) begin
                chk("R2 bit", bit_out, VECS[i].dat);
                chk("R4 pos", bit_pos, exp_pos);
                chk("R5 frame_start", frame_start, exp_pos == 0);
                exp_pos++;
            end
        end

        // R4 wrap and R9 deferred mode change to loop timing
        for (int p = exp_pos; p < 1536; p++) begin
            if (p == 100) cfg_loop = 1'b1;
            step(1'b1, 1'b0, p[0], 4'h0, 1'b0);
            if (p == 200) chk("R9 old mode still ticks", bit_valid, 1);
            if (p == 1535) begin
                chk("R4 last pos", bit_pos, 1535);
                chk("R5 no start at last", frame_start, 0);
            end
        end
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R9 R3 local ignored after boundary", bit_valid, 0);
        step(1'b0, 1'b1, 1'b1, 4'h0, 1'b0);
        chk("R4 wrap pos", bit_pos, 0);
        chk("R5 start after wrap", frame_start, 1);
        chk("R3 bit", bit_out, 1);
        step(1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
        chk("R3 pos", bit_pos, 1);

        // R1 loop timing ignores slave option
        do_reset(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 4'h0, 1'b0);
        chk("R3 loc ignored", bit_valid, 0);
        step(1'b0, 1'b1, 1'b1, 4'h0, 1'b0);
        chk("R1 free-run start", frame_start, 1);
        chk("R1 pos", bit_pos, 0);
        step(1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
        chk("R1 advances", bit_pos, 1);

        // R6 R7 slave alignment
        do_reset(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 2; k++) begin
            step(1'b1, 1'b0, 1'b1, 4'h0, 1'b0);
            chk("R6 held pos", bit_pos, 0);
            chk("R6 no start", frame_start, 0);
            chk("R6 valid", bit_valid, 1);
        end
        step(1'b1, 1'b0, 1'b1, 4'h0, 1'b1);
        chk("R7 edge start", frame_start, 1);
        chk("R7 edge pos", bit_pos, 0);
        for (int k = 1; k <= 4; k++) begin
            step(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
            chk("R7 level no restart", bit_pos, k);
        end
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R7 pos before truncation", bit_pos, 5);
        step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
        chk("R7 no tick no output", bit_valid, 0);
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
        chk("R7 truncate pos", bit_pos, 0);
        chk("R7 truncate start", frame_start, 1);
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
        chk("R7 after truncate", bit_pos, 1);

        // R8 nibble mode
        do_reset(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'hA, 1'b0);
        chk("R8 take lane0", take_s, 1);
        chk("R8 bit3 of A", bit_out, 1);
        chk("R5 nibble start", frame_start, 1);
        step(1'b1, 1'b0, 1'b0, 4'hF, 1'b0);
        chk("R8 no take lane1", take_s, 0);
        chk("R8 bit2 of A", bit_out, 0);
        step(1'b0, 1'b0, 1'b0, 4'hF, 1'b0);
        chk("R8 no take without tick", take_s, 0);
        step(1'b1, 1'b0, 1'b0, 4'hF, 1'b0);
        chk("R8 bit1 of A", bit_out, 1);
        step(1'b1, 1'b0, 1'b0, 4'hF, 1'b0);
        chk("R8 bit0 of A", bit_out, 0);
        step(1'b1, 1'b0, 1'b0, 4'h6, 1'b0);
        chk("R8 take second", take_s, 1);
        chk("R8 bit3 of 6", bit_out, 0);
        chk("R8 pos", bit_pos, 4);
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R8 bit2 of 6", bit_out, 1);
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R8 bit1 of 6", bit_out, 1);
        step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R8 bit0 of 6", bit_out, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule